// File: doc/BRIEF.md
# Sector Interleave Map Generator

This block produces the placement of logical sectors around a disk track for a chosen interleave. After a start pulse it emits one entry per clock: a physical sector position and the logical sector number to be recorded there. A formatting engine consumes the stream to write ID fields, so that a later multi-sector transfer finds each next logical sector a few physical positions ahead instead of one revolution away.

The map is built by stepping: position 0 holds logical 0, and each next position holds the previous value plus the interleave code. When that sum would reach the sector count, the sequence restarts one above the value that opened the current run. Each residue class modulo the code is therefore walked in turn. The gaps between consecutive logical sectors shrink by one near the end of the track, so the map is not a plain multiply-modulo table. For 32 sectors and code 7 the map opens 0, 7, 14, 21, 28, 1, 8, and closes 6, 13, 20, 27.

The sector count and code are captured when a start is accepted, so the inputs may change freely while a map is being emitted. A configuration that cannot form a map is refused with a one-cycle error pulse.

Top module: `ilv_map_gen`

## Requirements
- R1: The first entry after an accepted start has physical index 0 and logical value 0. The physical index then rises by one on every following clock with ent_valid high, up to count−1, with no gap.
- R2: While the sum of the previous logical value and the code stays below the captured count, the next entry's logical value equals that sum.
- R3: When that sum reaches or exceeds the count, the next logical value is one above the logical value that opened the current run. With count 32 and code 7, positions 1, 5, 10 hold 7, 1, 2, and positions 28 to 31 hold 6, 13, 20, 27.
- R4: Over one map of count N, each logical value 0 to N−1 appears exactly once, and every value is below N.
- R5: A start with code 0, a code not below the count, or a count above MAX_SECTORS (104 by default) produces cfg_err high for exactly the one cycle after the start edge, and no ent_valid.
- R6: map_done is high in the same cycle as the entry with physical index N−1, and only in that cycle.
- R7: A start arriving while a map is running, other than in its final cycle, is ignored. The running map continues unchanged with its captured count and code.
- R8: A start sampled in the cycle where map_done is high is accepted. The new map's entry 0 appears on the next clock with ent_valid held high throughout.
- R9: While reset is asserted, ent_valid, map_done, cfg_err, phys_idx and log_sec are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new map (sampled on the clock edge) |
| sec_count | input | W (7) | Sectors per track, captured at start |
| ilv_code | input | W (7) | Interleave step, captured at start |
| phys_idx | output | W (7) | Physical sector position of the current entry |
| log_sec | output | W (7) | Logical sector number for that position |
| ent_valid | output | 1 | Current entry is valid |
| map_done | output | 1 | Current entry is the last of the map |
| cfg_err | output | 1 | One-cycle pulse: the requested configuration was refused |

## Verification
The functions that can meet in one cycle are the end of a map, when map_done is shown, and the acceptance of a new start. The bench provokes this by waiting until it observes map_done and then raising start in that same cycle with a different count and code. A behavioural model built from per-residue loops judges the result. It expects the new map's entry 0 on the very next clock with no idle cycle. A second case raises start in the middle of a map with other parameters, and the model expects that start to leave the running stream untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } ilv_state_e;
endpackage

// File: rtl/ilv_cfg_check.sv
module ilv_cfg_check #(
  parameter int MAX_SECTORS = 104,
  parameter int W           = 7
) (
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] code_i,
  output logic         ok_o
);
  always_comb begin
    ok_o = (code_i != '0) && (code_i < count_i) && (int'(count_i) <= MAX_SECTORS);
  end
endmodule

// File: rtl/ilv_next_val.sv
module ilv_next_val #(
  parameter int W = 7
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] code_i,
  input  logic [W-1:0] count_i,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] nbase_o
);
  logic [W:0] sum;
  logic       wrap;

  always_comb begin
    sum     = {1'b0, cur_i} + {1'b0, code_i};
    wrap    = (sum >= {1'b0, count_i});
    nbase_o = wrap ? (base_i + W'(1)) : base_i;
    nxt_o   = wrap ? (base_i + W'(1)) : sum[W-1:0];
  end
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
  import ilv_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cfg_ok_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] phys_o,
  output logic [W-1:0] log_o,
  output logic         valid_o,
  output logic         done_o,
  output logic         err_o
);
  ilv_state_e  state_q, state_d;
  logic [W-1:0] phys_q, phys_d;
  logic [W-1:0] log_q, log_d;
  logic [W-1:0] base_q, base_d;
  logic [W-1:0] n_q, n_d;
  logic [W-1:0] code_q, code_d;
  logic         done_q, done_d;
  logic         err_q, err_d;
  logic         data_en;
  logic         running, last, accept;
  logic [W-1:0] nxt_val, nxt_base;

  ilv_next_val #(.W(W)) u_next (
    .cur_i  (log_q),
    .base_i (base_q),
    .code_i (code_q),
    .count_i(n_q),
    .nxt_o  (nxt_val),
    .nbase_o(nxt_base)
  );

  always_comb begin
    running = (state_q == S_RUN);
    last    = running && (phys_q == n_q - W'(1));
    accept  = start_i && (!running || last);
    state_d = state_q;
    phys_d  = phys_q;
    log_d   = log_q;
    base_d  = base_q;
    n_d     = n_q;
    code_d  = code_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    data_en = 1'b0;
    if (accept) begin
      if (cfg_ok_i) begin
        data_en = 1'b1;
        state_d = S_RUN;
        phys_d  = '0;
        log_d   = '0;
        base_d  = '0;
        n_d     = count_i;
        code_d  = code_i;
      end else begin
        state_d = S_IDLE;
        err_d   = 1'b1;
      end
    end else if (running) begin
      if (last) begin
        state_d = S_IDLE;
      end else begin
        data_en = 1'b1;
        phys_d  = phys_q + W'(1);
        log_d   = nxt_val;
        base_d  = nxt_base;
        done_d  = ((phys_q + W'(1)) == (n_q - W'(1)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_q <= '0;
      log_q  <= '0;
      base_q <= '0;
      n_q    <= '0;
      code_q <= '0;
    end else if (data_en) begin
      phys_q <= phys_d;
      log_q  <= log_d;
      base_q <= base_d;
      n_q    <= n_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    valid_o = running;
    phys_o  = running ? phys_q : '0;
    log_o   = running ? log_q : '0;
    done_o  = done_q;
    err_o   = err_q;
  end

  // R1: the first entry of every map carries logical 0
  a_r1_first_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && phys_o == '0) |-> (log_o == '0));

  // R1: the physical index advances by one with no gap
  a_r1_phys_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && phys_o != '0) |-> (phys_o == $past(phys_o) + W'(1)));

  // R2: below the count the value advances by the code
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && phys_o != '0 &&
     (int'($past(log_o)) + int'(code_q) < int'(n_q)))
    |-> (int'(log_o) == int'($past(log_o)) + int'(code_q)));

  // R3: a wrap lands on a new run start, which is always below the code
  a_r3_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o) && phys_o != '0 &&
     (int'($past(log_o)) + int'(code_q) >= int'(n_q)))
    |-> (log_o < code_q));

  // R4: every emitted value lies inside the track
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (log_o < n_q));

  // R5: a refused configuration never shows an entry
  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  // R6: done only marks the final entry, for one cycle
  a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (valid_o && phys_o == n_q - W'(1)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/ilv_map_gen.sv
module ilv_map_gen #(
  parameter int MAX_SECTORS = 104,
  localparam int W          = $clog2(MAX_SECTORS + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] sec_count,
  input  logic [W-1:0] ilv_code,
  output logic [W-1:0] phys_idx,
  output logic [W-1:0] log_sec,
  output logic         ent_valid,
  output logic         map_done,
  output logic         cfg_err
);
  logic cfg_ok;

  ilv_cfg_check #(.MAX_SECTORS(MAX_SECTORS), .W(W)) u_cfg (
    .count_i(sec_count),
    .code_i (ilv_code),
    .ok_o   (cfg_ok)
  );

  ilv_seq #(.W(W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .cfg_ok_i(cfg_ok),
    .count_i (sec_count),
    .code_i  (ilv_code),
    .phys_o  (phys_idx),
    .log_o   (log_sec),
    .valid_o (ent_valid),
    .done_o  (map_done),
    .err_o   (cfg_err)
  );

  // R5: an error pulse lasts exactly one cycle unless a fresh start follows
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !$past(start)) |-> 1'b0);
endmodule

// File: tb/ilv_map_gen_bench.sv
module ilv_map_gen_bench;
  localparam int MAXS = 104;
  localparam int W    = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] cnt_in = '0;
  logic [W-1:0] code_in = '0;
  logic [W-1:0] phys_idx, log_sec;
  logic         ent_valid, map_done, cfg_err;

  ilv_map_gen #(.MAX_SECTORS(MAXS)) u_ilv_map_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sec_count(cnt_in),
    .ilv_code (code_in),
    .phys_idx (phys_idx),
    .log_sec  (log_sec),
    .ent_valid(ent_valid),
    .map_done (map_done),
    .cfg_err  (cfg_err)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  int exp_list[$];
  int pos = 0;
  int exp_err = 0;
  int cur_n = 0;
  bit m_show, m_last;
  int seen [0:127];
  int rec  [0:127];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build(input int n, input int c);
    exp_list.delete();
    for (int r = 0; r < c; r++)
      for (int v = r; v < n; v += c)
        exp_list.push_back(v);
  endtask

  // reference model, updated on the edge from the inputs driven at negedge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_list.delete();
      pos = 0;
      exp_err = 0;
    end else begin
      m_show = (pos < exp_list.size());
      m_last = m_show && (pos == exp_list.size() - 1);
      exp_err = 0;
      if (start && (!m_show || m_last)) begin
        if (code_in != 0 && code_in < cnt_in && int'(cnt_in) <= MAXS) begin
          build(int'(cnt_in), int'(code_in));
          cur_n = int'(cnt_in);
        end else begin
          exp_list.delete();
          exp_err = 1;
        end
        pos = 0;
      end else if (m_show) begin
        pos++;
      end
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      m_show = (pos < exp_list.size());
      chk(ent_valid == m_show, "R7 R8 valid", int'(ent_valid), int'(m_show));
      chk(cfg_err == (exp_err != 0), "R5 cfg_err", int'(cfg_err), exp_err);
      chk(map_done == (m_show && pos == exp_list.size() - 1), "R6 done",
          int'(map_done), int'(m_show && pos == exp_list.size() - 1));
      if (m_show && ent_valid) begin
        chk(int'(phys_idx) == pos, "R1 phys", int'(phys_idx), pos);
        chk(int'(log_sec) == exp_list[pos], "R2 R3 logical", int'(log_sec), exp_list[pos]);
      end
      if (ent_valid) begin
        if (phys_idx == 0)
          for (int i = 0; i < 128; i++) seen[i] = 0;
        seen[log_sec]++;
        rec[phys_idx] = int'(log_sec);
        if (map_done)
          for (int i = 0; i < cur_n; i++)
            chk(seen[i] == 1, "R4 permutation", seen[i], 1);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic go(input int n, input int c);
    @(negedge clk);
    start = 1'b1;
    cnt_in = W'(n);
    code_in = W'(c);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (ent_valid) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(ent_valid == 1'b0, "R9 valid", int'(ent_valid), 0);
    chk(map_done == 1'b0, "R9 done", int'(map_done), 0);
    chk(cfg_err == 1'b0, "R9 err", int'(cfg_err), 0);
    chk(phys_idx == '0 && log_sec == '0, "R9 data", int'(log_sec), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: the 32 / 7 example
    go(32, 7);
    wait_idle();
    chk(rec[1] == 7, "R2 pos1", rec[1], 7);
    chk(rec[5] == 1, "R3 pos5", rec[5], 1);
    chk(rec[10] == 2, "R3 pos10", rec[10], 2);
    chk(rec[28] == 6, "R3 pos28", rec[28], 6);
    chk(rec[29] == 13, "R3 pos29", rec[29], 13);
    chk(rec[30] == 20, "R3 pos30", rec[30], 20);
    chk(rec[31] == 27, "R3 pos31", rec[31], 27);

    go(32, 16); wait_idle();
    go(32, 11); wait_idle();
    go(32, 8);  wait_idle();
    go(60, 15); wait_idle();
    go(104, 52); wait_idle();
    go(104, 35); wait_idle();
    go(104, 26); wait_idle();
    go(104, 21); wait_idle();
    go(104, 103); wait_idle();
    go(60, 1);  wait_idle();
    go(2, 1);   wait_idle();

    // R5: refused configurations
    go(32, 0);   wait_idle();
    go(32, 32);  wait_idle();
    go(32, 40);  wait_idle();
    go(105, 3);  wait_idle();
    go(0, 0);    wait_idle();

    // R7: start in the middle of a map is ignored
    go(60, 3);
    repeat (5) @(negedge clk);
    start = 1'b1; cnt_in = W'(32); code_in = W'(7);
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R8: start coinciding with done chains without a gap
    go(32, 11);
    while (!map_done) @(negedge clk);
    start = 1'b1; cnt_in = W'(60); code_in = W'(15);
    @(negedge clk);
    start = 1'b0;
    chk(ent_valid == 1'b1 && phys_idx == '0, "R8 chained entry 0", int'(phys_idx), 0);
    while (!map_done) @(negedge clk);
    start = 1'b1; cnt_in = W'(32); code_in = W'(0);
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err == 1'b1 && ent_valid == 1'b0, "R5 R8 refused at done", int'(cfg_err), 1);
    wait_idle();

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule